// File: doc/BRIEF.md
# Dual halfword signed multiply-accumulate

This datapath unit takes two 32-bit operands and treats each one as a pair of signed 16-bit halfwords. It multiplies the low halves together and the high halves together. It then adds or subtracts the two products and adds the combined value to an accumulator. Before the multiplication, the halfwords of the second operand can be exchanged, which pairs the low half of one operand with the high half of the other.

The unit has two modes. Long mode accumulates into a 64-bit value that arrives as a high word and a low word. Each product is widened to 64 bits on its own before it is combined, so a sum that no longer fits in 32 bits keeps its true sign. Short mode works in 32 bits with wrap-around and raises a sticky saturation flag (Q) on signed overflow.

One register stage holds the result. A two-state controller marks that register as fresh or stale:
- `ST_EMPTY`: no new result this cycle. It moves to `ST_HOLD` when `in_valid` is high and stays put otherwise.
- `ST_HOLD`: a result was captured on the last edge. It stays in `ST_HOLD` while `in_valid` stays high and returns to `ST_EMPTY` when it drops.

Top module: `dmac_top`

## Requirements
- R1: When `swap` is 1, operand B is rotated right by 16 bits before use, so its two halfwords trade places. When `swap` is 0, B is used as given.
- R2: Product 1 is signed A[15:0] times signed B'[15:0], and product 2 is signed A[31:16] times signed B'[31:16], where B' is operand B after the optional swap.
- R3: In long mode (`long_mode`=1), each product is sign-extended to 64 bits on its own, the two are combined, and the combination is added to {`acc_hi`,`acc_lo`}. The sum wraps modulo 2^64. `res_hi` carries bits 63:32 of the sum and `res_lo` carries bits 31:0.
- R4: In long mode with zero accumulator, two products of 0x40000000 give `res_hi`=0x00000000 and `res_lo`=0x80000000, a positive value.
- R5: `sub`=0 combines the products as product1 + product2, and `sub`=1 combines them as product1 − product2.
- R6: In short mode (`long_mode`=0), the 32-bit combination of the products is added to `acc_s` with 32-bit wrap-around. The sum appears on `res_lo`, and `res_hi` reads 0.
- R7: In short mode, a signed overflow of product1 + product2 sets Q. Subtracting the products never sets Q.
- R8: In short mode, a signed overflow of the addition to `acc_s` sets Q.
- R9: Once set, Q stays set until reset. Long-mode operations never change Q.
- R10: `out_valid` is high exactly one clock after a cycle with `in_valid` high and low otherwise. `res_hi` and `res_lo` keep their value when `in_valid` is low.
- R11: Synchronous active-high `rst` clears `out_valid`, `q_flag`, `res_hi` and `res_lo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands valid this cycle |
| op_a | input | 32 | Operand A (two signed halfwords) |
| op_b | input | 32 | Operand B (two signed halfwords) |
| swap | input | 1 | Exchange the halfwords of B |
| sub | input | 1 | 1: subtract product 2 from product 1; 0: add them |
| long_mode | input | 1 | 1: 64-bit accumulate; 0: 32-bit accumulate |
| acc_hi | input | 32 | Upper word of the 64-bit accumulator |
| acc_lo | input | 32 | Lower word of the 64-bit accumulator |
| acc_s | input | 32 | 32-bit accumulator for short mode |
| res_hi | output | 32 | Result bits 63:32 (0 in short mode) |
| res_lo | output | 32 | Result bits 31:0 |
| q_flag | output | 1 | Sticky short-mode overflow |
| out_valid | output | 1 | Result registered this cycle |

## Verification
The bench builds the unit with the default halfword width of 16, so the 0x8000 and 0x7FFF extremes of each half are reachable. The bench drives every pairing of those extremes through all eight combinations of swap, subtract and mode. These cases include the one that makes a 32-bit product sum change sign and the single product pair whose subtraction lands at the edge of the signed range. Directed accumulator values next to the positive limit force the short-mode accumulate overflow. Random operands cover the rest, checked each cycle against a model that widens each product separately.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HOLD  = 1'b1
    } dmac_state_e;
endpackage

// File: rtl/dmac_halfmul.sv
module dmac_halfmul #(
    parameter int HW = 16
) (
    input  logic [HW-1:0]          x,
    input  logic [HW-1:0]          y,
    output logic signed [2*HW-1:0] p
);
    always_comb begin
        p = $signed(x) * $signed(y);
    end
endmodule

// File: rtl/dmac_combine.sv
module dmac_combine #(
    parameter int DW = 32
) (
    input  logic signed [DW-1:0]   p1,
    input  logic signed [DW-1:0]   p2,
    input  logic                   sub,
    input  logic [2*DW-1:0]        acc_long,
    input  logic [DW-1:0]          acc_short,
    output logic [2*DW-1:0]        long_sum,
    output logic [DW-1:0]          pair,
    output logic [DW-1:0]          short_sum,
    output logic                   ovf_pair,
    output logic                   ovf_acc
);
    localparam int LW  = 2 * DW;
    localparam int MSB = DW - 1;

    logic [LW-1:0] e1, e2, comb;

    always_comb begin
        // widen each product independently before combining
        e1       = {{DW{p1[MSB]}}, p1};
        e2       = {{DW{p2[MSB]}}, p2};
        comb     = sub ? (e1 - e2) : (e1 + e2);
        long_sum = comb + acc_long;

        pair      = sub ? (p1 - p2) : (p1 + p2);
        ovf_pair  = !sub && (p1[MSB] == p2[MSB]) && (pair[MSB] != p1[MSB]);
        short_sum = pair + acc_short;
        ovf_acc   = (pair[MSB] == acc_short[MSB]) && (short_sum[MSB] != pair[MSB]);
    end
endmodule

// File: rtl/dmac_top.sv
module dmac_top #(
    parameter int HW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2*HW-1:0]   op_a,
    input  logic [2*HW-1:0]   op_b,
    input  logic              swap,
    input  logic              sub,
    input  logic              long_mode,
    input  logic [2*HW-1:0]   acc_hi,
    input  logic [2*HW-1:0]   acc_lo,
    input  logic [2*HW-1:0]   acc_s,
    output logic [2*HW-1:0]   res_hi,
    output logic [2*HW-1:0]   res_lo,
    output logic              q_flag,
    output logic              out_valid
);
    import dmac_pkg::*;

    localparam int DW = 2 * HW;
    localparam int LW = 2 * DW;
    localparam int NPROD = 2;

    dmac_state_e state, state_nxt;

    logic [DW-1:0]        b_sel;
    logic signed [DW-1:0] prod [NPROD];
    logic [LW-1:0]        long_sum;
    logic [DW-1:0]        pair, short_sum;
    logic                 ovf_pair, ovf_acc;

    always_comb begin
        b_sel = swap ? {op_b[HW-1:0], op_b[DW-1:HW]} : op_b;
    end

    for (genvar g = 0; g < NPROD; g++) begin : g_mul
        dmac_halfmul #(.HW(HW)) u_mul (
            .x (op_a[g*HW +: HW]),
            .y (b_sel[g*HW +: HW]),
            .p (prod[g])
        );
    end

    dmac_combine #(.DW(DW)) u_comb (
        .p1        (prod[0]),
        .p2        (prod[1]),
        .sub       (sub),
        .acc_long  ({acc_hi, acc_lo}),
        .acc_short (acc_s),
        .long_sum  (long_sum),
        .pair      (pair),
        .short_sum (short_sum),
        .ovf_pair  (ovf_pair),
        .ovf_acc   (ovf_acc)
    );

    // next-state logic
    always_comb begin
        unique case (state)
            ST_EMPTY: state_nxt = in_valid ? ST_HOLD : ST_EMPTY;
            ST_HOLD:  state_nxt = in_valid ? ST_HOLD : ST_EMPTY;
            default:  state_nxt = ST_EMPTY;
        endcase
    end

    // state and result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_EMPTY;
            res_hi <= '0;
            res_lo <= '0;
            q_flag <= 1'b0;
        end else begin
            state <= state_nxt;
            if (in_valid) begin
                if (long_mode) begin
                    res_hi <= long_sum[LW-1:DW];
                    res_lo <= long_sum[DW-1:0];
                end else begin
                    res_hi <= '0;
                    res_lo <= short_sum;
                    q_flag <= q_flag | ovf_pair | ovf_acc;
                end
            end
        end
    end

    // outputs
    always_comb begin
        out_valid = (state == ST_HOLD);
    end

    assert_valid_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_lo) && $stable(res_hi)));
    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        q_flag |=> q_flag);
    assert_longq_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && long_mode) |=> $stable(q_flag));
    assert_shorthi_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !long_mode) |=> (res_hi == '0));
    assert_subsafe_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sub) |-> ((prod[0][DW-1] == prod[1][DW-1]) || (pair[DW-1] == prod[0][DW-1])));
    assert_pairq_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !long_mode && ovf_pair) |=> q_flag);
endmodule

// File: tb/dmac_top_tb.sv
module dmac_top_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] op_a, op_b, acc_hi, acc_lo, acc_s;
    logic        swap, sub, long_mode;
    logic [31:0] res_hi, res_lo;
    logic        q_flag, out_valid;

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_hi = '0, exp_lo = '0;
    logic        exp_q = 1'b0;

    always #4 clk = ~clk;

    dmac_top #(.HW(16)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .swap(swap), .sub(sub), .long_mode(long_mode), .acc_hi(acc_hi),
        .acc_lo(acc_lo), .acc_s(acc_s), .res_hi(res_hi), .res_lo(res_lo),
        .q_flag(q_flag), .out_valid(out_valid)
    );

    task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [31:0] a, input logic [31:0] b, input logic sw,
                         input logic sb, input logic lg, input logic [31:0] ah,
                         input logic [31:0] al, input logic [31:0] as);
        logic [31:0] b2;
        longint p1, p2, c, t;
        logic [63:0] r;
        b2 = sw ? {b[15:0], b[31:16]} : b;
        p1 = longint'($signed(a[15:0])) * longint'($signed(b2[15:0]));
        p2 = longint'($signed(a[31:16])) * longint'($signed(b2[31:16]));
        c  = sb ? (p1 - p2) : (p1 + p2);
        if (lg) begin
            r = 64'(c) + {ah, al};
            exp_hi = r[63:32];
            exp_lo = r[31:0];
        end else begin
            if (c > 64'sd2147483647 || c < -64'sd2147483648) exp_q = 1'b1;
            r = 64'(c);
            t = longint'($signed(r[31:0])) + longint'($signed(as));
            if (t > 64'sd2147483647 || t < -64'sd2147483648) exp_q = 1'b1;
            r = 64'(t);
            exp_hi = '0;
            exp_lo = r[31:0];
        end
    endtask

    task automatic step(input logic [31:0] a, input logic [31:0] b, input logic sw,
                        input logic sb, input logic lg, input logic [31:0] ah,
                        input logic [31:0] al, input logic [31:0] as, input string tag);
        in_valid = 1'b1; op_a = a; op_b = b; swap = sw; sub = sb; long_mode = lg;
        acc_hi = ah; acc_lo = al; acc_s = as;
        model(a, b, sw, sb, lg, ah, al, as);
        @(negedge clk);
        cmp({tag, " R10 valid"}, 64'(out_valid), 64'd1);
        cmp({tag, " hi"}, 64'(res_hi), 64'(exp_hi));
        cmp({tag, " lo"}, 64'(res_lo), 64'(exp_lo));
        cmp({tag, " R9 q"}, 64'(q_flag), 64'(exp_q));
    endtask

    task automatic idle();
        in_valid = 1'b0; op_a = $urandom; op_b = $urandom; acc_s = $urandom;
        @(negedge clk);
        cmp("R10 idle valid", 64'(out_valid), 64'd0);
        cmp("R10 idle hold", {res_hi, res_lo}, {exp_hi, exp_lo});
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        exp_q = 1'b0; exp_hi = '0; exp_lo = '0;
        cmp("R11 valid", 64'(out_valid), 64'd0);
        cmp("R11 q", 64'(q_flag), 64'd0);
        cmp("R11 res", {res_hi, res_lo}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] hv [2];
        hv[0] = 16'h8000; hv[1] = 16'h7FFF;
        in_valid = 0; op_a = 0; op_b = 0; swap = 0; sub = 0; long_mode = 0;
        acc_hi = 0; acc_lo = 0; acc_s = 0;
        @(negedge clk);
        do_reset();

        // R4: two products of 0x40000000
        step(32'h8000_8000, 32'h8000_8000, 0, 0, 1, 0, 0, 0, "R4");
        cmp("R4 positive hi", 64'(res_hi), 64'h0);
        cmp("R4 positive lo", 64'(res_lo), 64'h8000_0000);
        // R1 swap and R2 lane pairing
        step(32'h0003_0002, 32'h0005_0007, 1, 0, 1, 0, 0, 0, "R1");
        step(32'h0003_0002, 32'h0005_0007, 0, 0, 1, 0, 0, 0, "R2");
        // R5 subtract, R3 accumulate with wrap
        step(32'h0001_0004, 32'h0002_0003, 0, 1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R5");
        step(32'hFFFF_0001, 32'h0001_0001, 0, 0, 1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, "R3");
        idle();
        // R6 short, R7 subtraction never overflows
        step(32'h7FFF_8000, 32'h8000_8000, 0, 1, 0, 0, 0, 32'h0000_0010, "R7");
        step(32'h0002_0003, 32'h0004_0005, 0, 0, 0, 0, 0, 32'hFFFF_FFF0, "R6");
        // R7 pair add overflow
        step(32'h8000_8000, 32'h8000_8000, 0, 0, 0, 0, 0, 0, "R7");
        do_reset();
        // R8 accumulate overflow
        step(32'h0001_0001, 32'h0001_0001, 0, 0, 0, 0, 0, 32'h7FFF_FFFF, "R8");
        // R9 long does not touch q, sticky across a clean short op
        step(32'h0001_0001, 32'h0001_0001, 0, 0, 1, 0, 0, 0, "R9");
        step(32'h0001_0001, 32'h0001_0001, 0, 0, 0, 0, 0, 0, "R9");
        do_reset();

        // corners: every pairing of 0x8000 / 0x7FFF in all mode combos
        for (int ai = 0; ai < 4; ai++)
            for (int bi = 0; bi < 4; bi++)
                for (int m = 0; m < 8; m++)
                    step({hv[ai[1]], hv[ai[0]]}, {hv[bi[1]], hv[bi[0]]}, m[0], m[1], m[2],
                         32'h8000_0000, 32'h0000_0001, 32'h7FFF_FFFF, m[2] ? "R3" : "R6");
        do_reset();

        // random
        for (int i = 0; i < 400; i++) begin
            step($urandom, $urandom, 1'($urandom), 1'($urandom), 1'($urandom),
                 $urandom, $urandom, $urandom, "R2");
            if (i % 7 == 0) idle();
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule